// File: doc/BRIEF.md
# Dual-Mechanism PCI Configuration Decoder

This block sits in a host bridge and turns processor I/O port accesses into PCI configuration requests. It offers two ways in. The first is a key-gated I/O window. A byte at port 0x0CF8 holds a key and a function number. While the window is open, an access to 0xCdii addresses device d, register ii, using the bus number held at port 0x0CFA. The second is the address/data method. Port 0x0CF8 then holds a 32-bit address register, and ports 0x0CFC to 0x0CFF carry the data bytes.

Bit 0 of the byte at port 0x0CFB selects the method at run time. The state of the other method is kept while it is inactive. When the build option for the first device is set, the lowest 256 ports of the window page are decoded at all times. Only the rest of the page waits for the key.

Downstream, each access produces a one-cycle request. The request carries bus, device, function, register index, a write flag and a write byte. The device side answers in the same cycle with a read byte and a present flag.

Top module: `pcicfg_decoder`

## Requirements
- R1: After reset the window method is selected, and the key, function, bus and address register are zero. Reads of 0x0CF8, 0x0CFA and 0x0CFB return 0x00 in the low byte, and the window is closed.
- R2: In window mode, a write to 0x0CF8 stores the key from data bits 7:4 and the function from bits 3:1. A read returns {key, function, 0}, so a written bit 0 reads back as zero.
- R3: In window mode, 0x0CFA stores the 8-bit bus number and reads it back. Writing 0x0CFA also opens the window, even when the key is zero.
- R4: While the window is open in window mode, an access to port 0xCdii (page 0xC by default) raises cfg_req for one cycle. The request carries device d (bits 11:8, zero-extended to 5 bits), register ii (bits 7:0), the stored bus and function, cfg_we equal to the write strobe, and the write byte from io_wdata[7:0].
- R5: A window-mode write of 0x0CF8 with key bits 7:4 equal to zero closes the window. After that, window-page accesses raise no request and reads return 0xFF.
- R6: With EXPOSE_DEV0 set, ports 0xC000 to 0xC0FF are decoded as device 0 in window mode whatever the key. With EXPOSE_DEV0 clear, these ports follow the key like the rest of the page.
- R7: A write to 0x0CFB stores the byte and it reads back. Stored bit 0 = 1 selects the address/data method and bit 0 = 0 selects the window method, taking effect from the next cycle.
- R8: In address/data mode, 0x0CF8 is a 32-bit register written per byte lane under io_be and read back whole. Its fields are enable in bit 31, bus in 23:16, device in 15:11, function in 10:8 and register in 7:2.
- R9: In address/data mode with bit 31 set, an access to 0x0CFC+k (k = 0..3) raises a request to register {reg[7:2], k} with the register's bus, device and function. With bit 31 clear, no request is made and reads return 0xFF.
- R10: In address/data mode, the window page and port 0x0CFA are ignored: no request is made, reads return 0xFF and writes change nothing. In window mode, ports 0x0CFC to 0x0CFF are ignored.
- R11: Configuration read data appears on io_rdata[7:0] in the same cycle, with bits 31:8 all ones. The byte is 0xFF when cfg_present is low, and unclaimed reads return all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_be | input | IO_DW/8 | Byte enables for the 32-bit address register |
| io_wdata | input | IO_DW | Write data; byte ports use bits 7:0 |
| io_rdata | output | IO_DW | Read data, combinational |
| cfg_req | output | 1 | Configuration request valid |
| cfg_we | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus |
| cfg_dev | output | 5 | Target device |
| cfg_func | output | 3 | Target function |
| cfg_reg | output | 8 | Target register byte index |
| cfg_wdata | output | 8 | Write byte |
| cfg_rdata | input | 8 | Read byte from the device side |
| cfg_present | input | 1 | Addressed device exists |

## Verification
Window-page addresses are swept over all 16 device nibbles at fixed, edge and device-dependent register offsets. This separates the device field from the register field and shows where present devices end and absent ones return 0xFF. The address/data path is swept over all 32 device numbers and all four byte offsets, which shows that the port's low bits land in the register index. Mode-crossing sequences then show the following:
- the ports of the inactive method are ignored;
- its state is kept;
- opening the window by a bus write differs from opening it by a key;
- always-on decoding of the first device appears only in the build that asks for it. A second instance built without the option shares the bus to show this.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;
   localparam logic [15:0] PORT_ADDR = 16'h0CF8;
   localparam logic [15:0] PORT_BUS  = 16'h0CFA;
   localparam logic [15:0] PORT_MODE = 16'h0CFB;
   localparam logic [13:0] DATA_QUAD = 14'h033F;  // 0x0CFC..0x0CFF

   typedef struct packed {
      logic [7:0] bus;
      logic [4:0] dev;
      logic [2:0] func;
      logic [7:0] regi;
   } cfg_tgt_t;
endpackage

// File: rtl/pcicfg_regs.sv
module pcicfg_regs
   import pcicfg_pkg::*;
#(
   parameter int IO_DW = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [15:0]        io_addr,
   input  logic               io_wr,
   input  logic [IO_DW/8-1:0] io_be,
   input  logic [IO_DW-1:0]   io_wdata,
   output logic               mode_ad,
   output logic [7:0]         mode_byte,
   output logic [3:0]         key,
   output logic [2:0]         func,
   output logic [7:0]         bus,
   output logic               win_open,
   output logic [IO_DW-1:0]   cf8
);
   localparam int NB = IO_DW / 8;

   logic wr_addr, wr_bus, wr_mode;

   assign wr_addr = io_wr && (io_addr == PORT_ADDR);
   assign wr_bus  = io_wr && (io_addr == PORT_BUS);
   assign wr_mode = io_wr && (io_addr == PORT_MODE);
   assign mode_ad = mode_byte[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_byte <= '0;
      end else if (wr_mode) begin
         mode_byte <= io_wdata[7:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key      <= '0;
         func     <= '0;
         bus      <= '0;
         win_open <= 1'b0;
      end else if (!mode_ad) begin
         if (wr_addr) begin
            key      <= io_wdata[7:4];
            func     <= io_wdata[3:1];
            win_open <= |io_wdata[7:4];
         end
         if (wr_bus) begin
            bus      <= io_wdata[7:0];
            win_open <= 1'b1;
         end
      end
   end

   for (genvar b = 0; b < NB; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cf8[8*b +: 8] <= '0;
         end else if (mode_ad && wr_addr && io_be[b]) begin
            cf8[8*b +: 8] <= io_wdata[8*b +: 8];
         end
      end
   end
endmodule

// File: rtl/pcicfg_route.sv
module pcicfg_route
   import pcicfg_pkg::*;
#(
   parameter int         IO_DW       = 32,
   parameter logic [3:0] WIN_PAGE    = 4'hC,
   parameter bit         EXPOSE_DEV0 = 1'b1
) (
   input  logic [15:0]      io_addr,
   input  logic             io_rd,
   input  logic             io_wr,
   input  logic [IO_DW-1:0] io_wdata,
   input  logic             mode_ad,
   input  logic [7:0]       mode_byte,
   input  logic [3:0]       key,
   input  logic [2:0]       func,
   input  logic [7:0]       bus,
   input  logic             win_open,
   input  logic [IO_DW-1:0] cf8,
   input  logic [7:0]       cfg_rdata,
   input  logic             cfg_present,
   output logic             cfg_req,
   output logic             cfg_we,
   output cfg_tgt_t         tgt,
   output logic [7:0]       cfg_wdata,
   output logic [IO_DW-1:0] io_rdata
);
   localparam logic [IO_DW-9:0] HI_ONES = '1;

   logic in_page, win_ok, win_hit, dat_hit, hit;
   logic [7:0] byte_rd;

   assign in_page = (io_addr[15:12] == WIN_PAGE);

   if (EXPOSE_DEV0) begin : g_dev0_open
      assign win_ok = win_open || (io_addr[11:8] == 4'h0);
   end else begin : g_dev0_keyed
      assign win_ok = win_open;
   end

   assign win_hit   = !mode_ad && in_page && win_ok;
   assign dat_hit   = mode_ad && cf8[31] && (io_addr[15:2] == DATA_QUAD);
   assign hit       = win_hit || dat_hit;
   assign cfg_req   = (io_rd || io_wr) && hit;
   assign cfg_we    = io_wr && hit;
   assign cfg_wdata = io_wdata[7:0];
   assign byte_rd   = cfg_present ? cfg_rdata : 8'hFF;

   always_comb begin
      if (mode_ad) begin
         tgt = '{bus: cf8[23:16], dev: cf8[15:11], func: cf8[10:8],
                 regi: {cf8[7:2], io_addr[1:0]}};
      end else begin
         tgt = '{bus: bus, dev: {1'b0, io_addr[11:8]}, func: func,
                 regi: io_addr[7:0]};
      end
   end

   always_comb begin
      io_rdata = '1;
      if (io_rd) begin
         if (hit) begin
            io_rdata = {HI_ONES, byte_rd};
         end else if (io_addr == PORT_ADDR) begin
            io_rdata = mode_ad ? cf8 : {HI_ONES, key, func, 1'b0};
         end else if (io_addr == PORT_BUS && !mode_ad) begin
            io_rdata = {HI_ONES, bus};
         end else if (io_addr == PORT_MODE) begin
            io_rdata = {HI_ONES, mode_byte};
         end
      end
   end
endmodule

// File: rtl/pcicfg_decoder.sv
module pcicfg_decoder
   import pcicfg_pkg::*;
#(
   parameter int         IO_DW       = 32,
   parameter logic [3:0] WIN_PAGE    = 4'hC,
   parameter bit         EXPOSE_DEV0 = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [15:0]        io_addr,
   input  logic               io_rd,
   input  logic               io_wr,
   input  logic [IO_DW/8-1:0] io_be,
   input  logic [IO_DW-1:0]   io_wdata,
   output logic [IO_DW-1:0]   io_rdata,
   output logic               cfg_req,
   output logic               cfg_we,
   output logic [7:0]         cfg_bus,
   output logic [4:0]         cfg_dev,
   output logic [2:0]         cfg_func,
   output logic [7:0]         cfg_reg,
   output logic [7:0]         cfg_wdata,
   input  logic [7:0]         cfg_rdata,
   input  logic               cfg_present
);
   if (IO_DW != 32) begin : g_bad_width
      $error("pcicfg_decoder: IO_DW must be 32 for the address register");
   end
   if (WIN_PAGE == 4'h0) begin : g_bad_page
      $error("pcicfg_decoder: WIN_PAGE 0 overlaps the control ports");
   end

   logic             mode_ad, win_open;
   logic [7:0]       mode_byte, bus;
   logic [3:0]       key;
   logic [2:0]       func;
   logic [IO_DW-1:0] cf8;
   cfg_tgt_t         tgt;

   pcicfg_regs #(.IO_DW(IO_DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
      .io_be(io_be), .io_wdata(io_wdata), .mode_ad(mode_ad),
      .mode_byte(mode_byte), .key(key), .func(func), .bus(bus),
      .win_open(win_open), .cf8(cf8)
   );

   pcicfg_route #(.IO_DW(IO_DW), .WIN_PAGE(WIN_PAGE),
                  .EXPOSE_DEV0(EXPOSE_DEV0)) u_route (
      .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
      .mode_ad(mode_ad), .mode_byte(mode_byte), .key(key), .func(func),
      .bus(bus), .win_open(win_open), .cf8(cf8), .cfg_rdata(cfg_rdata),
      .cfg_present(cfg_present), .cfg_req(cfg_req), .cfg_we(cfg_we),
      .tgt(tgt), .cfg_wdata(cfg_wdata), .io_rdata(io_rdata)
   );

   assign cfg_bus  = tgt.bus;
   assign cfg_dev  = tgt.dev;
   assign cfg_func = tgt.func;
   assign cfg_reg  = tgt.regi;
endmodule

// File: rtl/pcicfg_decoder_chk.sv
module pcicfg_decoder_chk #(
   parameter int         IO_DW    = 32,
   parameter logic [3:0] WIN_PAGE = 4'hC
) (
   input logic             clk,
   input logic             rst_n,
   input logic [15:0]      io_addr,
   input logic             io_rd,
   input logic             io_wr,
   input logic [IO_DW-1:0] io_wdata,
   input logic [IO_DW-1:0] io_rdata,
   input logic             cfg_req,
   input logic             cfg_present,
   input logic             mode_ad,
   input logic             win_open,
   input logic [IO_DW-1:0] cf8
);
   // R3
   bus_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !mode_ad && io_addr == 16'h0CFA) |=> win_open);

   // R5
   zero_key_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !mode_ad && io_addr == 16'h0CF8 && io_wdata[7:4] == 4'h0)
      |=> !win_open);

   // R4
   window_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && !mode_ad) |-> (io_addr[15:12] == WIN_PAGE));

   // R9
   data_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && mode_ad) |-> (cf8[31] && io_addr[15:2] == 14'h033F));

   // R10
   window_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_ad && io_addr[15:12] == WIN_PAGE) |-> !cfg_req);

   // R7
   mode_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == 16'h0CFB) |=> (mode_ad == $past(io_wdata[0])));

   // R11
   absent_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && cfg_req && !cfg_present) |-> (io_rdata[7:0] == 8'hFF));
endmodule

bind pcicfg_decoder pcicfg_decoder_chk #(.IO_DW(IO_DW), .WIN_PAGE(WIN_PAGE)) u_chk (
   .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
   .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_req(cfg_req),
   .cfg_present(cfg_present), .mode_ad(mode_ad), .win_open(win_open), .cf8(cf8)
);

// File: tb/pcicfg_decoder_bench.sv
module pcicfg_decoder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_rd = 1'b0, io_wr = 1'b0;
   logic [3:0]  io_be = 4'b0001;
   logic [31:0] io_wdata = '0;

   logic [31:0] rd_m, rd_x;
   logic        req_m, we_m, req_x, we_x;
   logic [7:0]  bus_m, reg_m, wd_m, bus_x, reg_x, wd_x;
   logic [4:0]  dev_m, dev_x;
   logic [2:0]  fn_m, fn_x;
   logic [7:0]  crd_m, crd_x;
   logic        pres_m, pres_x;

   logic [7:0]  mem [0:3][0:255];
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pcicfg_decoder #(.EXPOSE_DEV0(1'b1)) u_pcicfg_decoder (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .io_be(io_be), .io_wdata(io_wdata), .io_rdata(rd_m), .cfg_req(req_m),
      .cfg_we(we_m), .cfg_bus(bus_m), .cfg_dev(dev_m), .cfg_func(fn_m),
      .cfg_reg(reg_m), .cfg_wdata(wd_m), .cfg_rdata(crd_m), .cfg_present(pres_m)
   );

   pcicfg_decoder #(.EXPOSE_DEV0(1'b0)) u_pcicfg_decoder_keyed (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .io_be(io_be), .io_wdata(io_wdata), .io_rdata(rd_x), .cfg_req(req_x),
      .cfg_we(we_x), .cfg_bus(bus_x), .cfg_dev(dev_x), .cfg_func(fn_x),
      .cfg_reg(reg_x), .cfg_wdata(wd_x), .cfg_rdata(crd_x), .cfg_present(pres_x)
   );

   // device model: devices 0..3 present, data mixed with bus and function
   always_comb begin
      pres_m = (dev_m < 5'd4);
      crd_m  = mem[dev_m[1:0]][reg_m] ^ bus_m ^ {fn_m, 5'b0};
      pres_x = (dev_x < 5'd4);
      crd_x  = mem[dev_x[1:0]][reg_x] ^ bus_x ^ {fn_x, 5'b0};
   end

   always @(posedge clk) if (req_m && we_m) mem[dev_m[1:0]][reg_m] <= wd_m;

   function automatic logic [7:0] init_val(int d, int r);
      return 8'((d * 37 + r) & 8'hFF);
   endfunction

   function automatic logic [31:0] exp_rd(int b, int d, int f, int r);
      if (d >= 4) return 32'hFFFF_FFFF;
      return {24'hFF_FFFF, init_val(d, r) ^ 8'(b) ^ 8'(f << 5)};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic do_rd(input logic [15:0] a, output logic [31:0] d,
                        output logic rq, output logic [23:0] t,
                        output logic [31:0] d2, output logic rq2);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1; io_be = 4'b0001;
      #1;
      d = rd_m; rq = req_m; t = {bus_m, dev_m, fn_m, reg_m};
      d2 = rd_x; rq2 = req_x;
      @(posedge clk); #1 io_rd = 1'b0;
   endtask

   task automatic do_wr(input logic [15:0] a, input logic [31:0] v,
                        input logic [3:0] be, output logic rq, output logic we,
                        output logic [23:0] t, output logic [7:0] wd);
      @(negedge clk);
      io_addr = a; io_wr = 1'b1; io_wdata = v; io_be = be;
      #1;
      rq = req_m; we = we_m; t = {bus_m, dev_m, fn_m, reg_m}; wd = wd_m;
      @(posedge clk); #1 io_wr = 1'b0; io_be = 4'b0001;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, d2;
      logic rq, rq2, we;
      logic [23:0] t;
      logic [7:0] wd;

      for (int i = 0; i < 4; i++)
         for (int r = 0; r < 256; r++) mem[i][r] = init_val(i, r);

      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      do_rd(16'h0CF8, d, rq, t, d2, rq2); chk(d == 32'hFFFF_FF00, "R1 key/func", d, 32'hFFFF_FF00);
      do_rd(16'h0CFA, d, rq, t, d2, rq2); chk(d == 32'hFFFF_FF00, "R1 bus", d, 32'hFFFF_FF00);
      do_rd(16'h0CFB, d, rq, t, d2, rq2); chk(d == 32'hFFFF_FF00, "R1 mode", d, 32'hFFFF_FF00);
      do_rd(16'hC305, d, rq, t, d2, rq2);
      chk(!rq && d == 32'hFFFF_FFFF, "R1 window closed", d, 32'hFFFF_FFFF);

      // R6 first device always decoded only in the exposing build
      do_rd(16'hC042, d, rq, t, d2, rq2);
      chk(rq && t == {8'h00, 5'd0, 3'd0, 8'h42}, "R6 dev0 target", t, {8'h00, 5'd0, 3'd0, 8'h42});
      chk(d == exp_rd(0, 0, 0, 8'h42), "R6 dev0 data", d, exp_rd(0, 0, 0, 8'h42));
      chk(!rq2 && d2 == 32'hFFFF_FFFF, "R6 keyed build closed", d2, 32'hFFFF_FFFF);

      // R2 key and function
      do_wr(16'h0CF8, 32'h37, 4'b0001, rq, we, t, wd);
      do_rd(16'h0CF8, d, rq, t, d2, rq2); chk(d == 32'hFFFF_FF36, "R2 readback", d, 32'hFFFF_FF36);

      // R4 / R11 window sweep over every device nibble
      for (int dv = 0; dv < 16; dv++) begin
         for (int k = 0; k < 4; k++) begin
            int r;
            r = (k == 0) ? 8'h00 : (k == 1) ? 8'h3C : (k == 2) ? 8'hFF : (dv * 16 + 1) & 8'hFF;
            do_rd(16'(16'hC000 + dv * 256 + r), d, rq, t, d2, rq2);
            chk(rq && t == {8'h00, 5'(dv), 3'd3, 8'(r)}, "R4 window target", t, {8'h00, 5'(dv), 3'd3, 8'(r)});
            chk(d == exp_rd(0, dv, 3, r), "R11 window data", d, exp_rd(0, dv, 3, r));
         end
      end

      // R5 zero key closes; R3 bus write opens again
      do_wr(16'h0CF8, 32'h00, 4'b0001, rq, we, t, wd);
      do_rd(16'hC500, d, rq, t, d2, rq2);
      chk(!rq && d == 32'hFFFF_FFFF, "R5 closed after zero key", d, 32'hFFFF_FFFF);
      do_wr(16'h0CFA, 32'h5C, 4'b0001, rq, we, t, wd);
      do_rd(16'h0CFA, d, rq, t, d2, rq2); chk(d == 32'hFFFF_FF5C, "R3 bus readback", d, 32'hFFFF_FF5C);
      do_rd(16'hC500, d, rq, t, d2, rq2);
      chk(rq && t == {8'h5C, 5'd5, 3'd0, 8'h00}, "R3 window opened by bus", t, {8'h5C, 5'd5, 3'd0, 8'h00});
      chk(d == 32'hFFFF_FFFF, "R11 absent device", d, 32'hFFFF_FFFF);

      // R4 window write
      do_wr(16'hC120, 32'hA5, 4'b0001, rq, we, t, wd);
      chk(rq && we && t == {8'h5C, 5'd1, 3'd0, 8'h20} && wd == 8'hA5, "R4 window write",
          {t, wd}, {8'h5C, 5'd1, 3'd0, 8'h20, 8'hA5});
      do_rd(16'hC120, d, rq, t, d2, rq2);
      chk(d == {24'hFF_FFFF, 8'hA5 ^ 8'h5C}, "R4 write readback", d, {24'hFF_FFFF, 8'hA5 ^ 8'h5C});

      // R5 zero key with function 5 closes; R6 dev0 still open
      do_wr(16'h0CF8, 32'h0A, 4'b0001, rq, we, t, wd);
      do_rd(16'hC120, d, rq, t, d2, rq2);
      chk(!rq && d == 32'hFFFF_FFFF, "R5 closed window", d, 32'hFFFF_FFFF);
      do_rd(16'hC020, d, rq, t, d2, rq2);
      chk(rq && t == {8'h5C, 5'd0, 3'd5, 8'h20}, "R6 dev0 with key zero", t, {8'h5C, 5'd0, 3'd5, 8'h20});
      chk(!rq2, "R6 keyed build ignores", {31'd0, rq2}, 32'd0);

      // R10 data ports ignored in window mode
      do_wr(16'h0CFC, 32'h11, 4'b0001, rq, we, t, wd);
      chk(!rq, "R10 data port write in window mode", {31'd0, rq}, 32'd0);
      do_rd(16'h0CFD, d, rq, t, d2, rq2);
      chk(!rq && d == 32'hFFFF_FFFF, "R10 data port read in window mode", d, 32'hFFFF_FFFF);

      // R7 switch to address/data mode
      do_wr(16'h0CFB, 32'h81, 4'b0001, rq, we, t, wd);
      do_rd(16'h0CFB, d, rq, t, d2, rq2); chk(d == 32'hFFFF_FF81, "R7 mode readback", d, 32'hFFFF_FF81);

      // R8 address register with byte enables
      do_wr(16'h0CF8, 32'h8002_1A40, 4'b1111, rq, we, t, wd);
      do_rd(16'h0CF8, d, rq, t, d2, rq2); chk(d == 32'h8002_1A40, "R8 full write", d, 32'h8002_1A40);
      do_wr(16'h0CF8, 32'hFFFF_FF77, 4'b0001, rq, we, t, wd);
      do_rd(16'h0CF8, d, rq, t, d2, rq2); chk(d == 32'h8002_1A77, "R8 lane write", d, 32'h8002_1A77);
      do_rd(16'h0CFD, d, rq, t, d2, rq2);
      chk(rq && t == {8'h02, 5'd3, 3'd2, 8'h75}, "R8 field positions", t, {8'h02, 5'd3, 3'd2, 8'h75});

      // R9 address/data sweep over all devices and byte offsets
      for (int dv = 0; dv < 32; dv++) begin
         do_wr(16'h0CF8, {1'b1, 7'd0, 8'h02, 5'(dv), 3'd1, 8'h10}, 4'b1111, rq, we, t, wd);
         for (int k = 0; k < 4; k++) begin
            do_rd(16'(16'h0CFC + k), d, rq, t, d2, rq2);
            chk(rq && t == {8'h02, 5'(dv), 3'd1, 8'(16 + k)}, "R9 data target", t, {8'h02, 5'(dv), 3'd1, 8'(16 + k)});
            chk(d == exp_rd(2, dv, 1, 16 + k), "R9 data read", d, exp_rd(2, dv, 1, 16 + k));
         end
      end
      do_wr(16'h0CF8, 32'h8002_1110, 4'b1111, rq, we, t, wd);
      do_wr(16'h0CFE, 32'h3C, 4'b0001, rq, we, t, wd);
      chk(rq && we && t == {8'h02, 5'd2, 3'd1, 8'h12} && wd == 8'h3C, "R9 data write",
          {t, wd}, {8'h02, 5'd2, 3'd1, 8'h12, 8'h3C});
      do_rd(16'h0CFE, d, rq, t, d2, rq2);
      chk(d == {24'hFF_FFFF, 8'h3C ^ 8'h02 ^ 8'h20}, "R9 write readback", d, {24'hFF_FFFF, 8'h3C ^ 8'h22});
      do_wr(16'h0CF8, 32'h0002_1110, 4'b1111, rq, we, t, wd);
      do_rd(16'h0CFC, d, rq, t, d2, rq2);
      chk(!rq && d == 32'hFFFF_FFFF, "R9 enable clear", d, 32'hFFFF_FFFF);

      // R10 window side ignored in address/data mode
      do_rd(16'hC000, d, rq, t, d2, rq2);
      chk(!rq && d == 32'hFFFF_FFFF, "R10 window page ignored", d, 32'hFFFF_FFFF);
      do_rd(16'h0CFA, d, rq, t, d2, rq2);
      chk(d == 32'hFFFF_FFFF, "R10 bus port ignored", d, 32'hFFFF_FFFF);
      do_wr(16'h0CFA, 32'h99, 4'b0001, rq, we, t, wd);

      // R7 back to window mode, state kept
      do_wr(16'h0CFB, 32'h00, 4'b0001, rq, we, t, wd);
      do_rd(16'h0CFB, d, rq, t, d2, rq2); chk(d == 32'hFFFF_FF00, "R7 mode cleared", d, 32'hFFFF_FF00);
      do_rd(16'h0CFA, d, rq, t, d2, rq2); chk(d == 32'hFFFF_FF5C, "R10 bus unchanged", d, 32'hFFFF_FF5C);
      do_rd(16'h0CF8, d, rq, t, d2, rq2); chk(d == 32'hFFFF_FF0A, "R2 key/func kept", d, 32'hFFFF_FF0A);
      do_rd(16'hC300, d, rq, t, d2, rq2);
      chk(!rq, "R5 window still closed", {31'd0, rq}, 32'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule